// File: doc/BRIEF.md
# Block Carry-Skip Adder

This block adds two unsigned N-bit operands and a carry input and returns the N-bit sum with a carry output. The operand width is divided into equal groups of BW bits. Inside each group the carry ripples bit by bit. Each group also has a bypass. When every bit position in the group has unequal operand bits, the group's carry input is sent straight to the next group. Otherwise the group's rippled carry is used. The arithmetic result is the same as plain ripple addition for every input. The bypass only shortens the path a carry takes through groups that would pass it on unchanged.

The default build is 20 bits in four groups of 5, and group 0 holds the least significant bits. The adder logic is combinational. The sum and carry are captured in output registers that have a synchronous active-high reset, so a result appears one clock edge after its operands are presented. N must be a whole multiple of BW, and elaboration stops with an error if it is not.

Top module: `csk_adder_top`

## Requirements
- R1: On each rising clock edge with `rst` low, `sum_q` takes the low N bits of `opa + opb + cin` evaluated on the inputs present at that edge.
- R2: On the same edge, `cout_q` takes bit N (the carry beyond the most significant bit) of that same addition.
- R3: When `rst` is high at a rising edge, `sum_q` and `cout_q` both become 0 on that edge. Between edges the outputs hold their values even while the inputs change.
- R4: If every bit pair in a group differs (a group propagate), the carry entering that group leaves it unchanged. With `opa ^ opb` all ones, `sum_q` is all `~cin` and `cout_q` equals `cin`.
- R5: If any bit pair in a group is equal, the group's carry output comes from its internal ripple. A pair of ones produces a carry even when the incoming carry is 0, and a pair of zeros stops an incoming carry.
- R6: A carry produced in a low group travels through higher groups that are all propagate and appears on `cout_q`, with every bit of those groups' sum equal to 0.
- R7: With both operands 0 and `cin` = 1, the sum is 1 and `cout_q` is 0. With both operands all ones and `cin` = 1, the sum is all ones and `cout_q` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| opa | input | N | First operand |
| opb | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_q | output | N | Registered sum |
| cout_q | output | 1 | Registered carry out of the top bit |

## Verification
The two mechanisms that can act in the same addition are the group bypass and a group's internal ripple. One group can generate a carry while the groups above it are all propagate. That carry must then cross those groups by the bypass in the same cycle. Directed vectors place a generate or a kill next to all-propagate groups, with `cin` set to 0 and to 1. Each registered result is compared against an independently computed `opa + opb + cin`. A checker also requires the bypass carry and the rippled carry of every group to agree on every cycle.

// File: rtl/csk_pkg.sv
package csk_pkg;
  function automatic int unsigned group_count(input int unsigned width, input int unsigned grp);
    return width / grp;
  endfunction
endpackage

// File: rtl/csk_group.sv
module csk_group #(
  parameter int unsigned BW = 5
) (
  input  logic [BW-1:0] ga,
  input  logic [BW-1:0] gb,
  input  logic          gci,
  output logic [BW-1:0] gsum,
  output logic          gco_ripple,
  output logic          gco_skip
);
  logic [BW-1:0] prop;
  logic [BW-1:0] gen;
  logic [BW:0]   chain;
  logic          grp_prop;

  assign prop     = ga ^ gb;
  assign gen      = ga & gb;
  assign chain[0] = gci;

  for (genvar i = 0; i < BW; i++) begin : g_bit
    assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
  end

  assign gsum       = prop ^ chain[BW-1:0];
  assign grp_prop   = &prop;
  assign gco_ripple = chain[BW];
  // bypass: an all-propagate group hands its carry-in straight on
  assign gco_skip   = grp_prop ? gci : chain[BW];
endmodule

// File: rtl/csk_chain.sv
module csk_chain #(
  parameter int unsigned N  = 20,
  parameter int unsigned BW = 5
) (
  input  logic [N-1:0]                              a,
  input  logic [N-1:0]                              b,
  input  logic                                      ci,
  output logic [N-1:0]                              s,
  output logic                                      co,
  output logic [csk_pkg::group_count(N, BW)-1:0]    rip_co,
  output logic [csk_pkg::group_count(N, BW)-1:0]    skp_co
);
  localparam int unsigned NG = csk_pkg::group_count(N, BW);

  if ((N % BW) != 0 || BW == 0) begin : g_bad_cfg
    $error("csk_chain: N must be a whole multiple of BW");
  end

  logic [NG:0] gc;
  assign gc[0] = ci;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    csk_group #(.BW(BW)) u_grp (
      .ga        (a[k*BW +: BW]),
      .gb        (b[k*BW +: BW]),
      .gci       (gc[k]),
      .gsum      (s[k*BW +: BW]),
      .gco_ripple(rip_co[k]),
      .gco_skip  (skp_co[k])
    );
    assign gc[k+1] = skp_co[k];
  end

  assign co = gc[NG];
endmodule

// File: rtl/csk_adder_top.sv
module csk_adder_top #(
  parameter int unsigned N  = 20,
  parameter int unsigned BW = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         cin,
  output logic [N-1:0] sum_q,
  output logic         cout_q
);
  localparam int unsigned NG = csk_pkg::group_count(N, BW);

  logic [N-1:0]  sum_d;
  logic          cout_d;
  logic [NG-1:0] rip_co;
  logic [NG-1:0] skp_co;

  csk_chain #(.N(N), .BW(BW)) u_chain (
    .a     (opa),
    .b     (opb),
    .ci    (cin),
    .s     (sum_d),
    .co    (cout_d),
    .rip_co(rip_co),
    .skp_co(skp_co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
  parameter int unsigned N  = 20,
  parameter int unsigned BW = 5,
  parameter int unsigned NG = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  opa,
  input logic [N-1:0]  opb,
  input logic          cin,
  input logic [N-1:0]  sum_q,
  input logic          cout_q,
  input logic [NG-1:0] rip_co,
  input logic [NG-1:0] skp_co
);
  function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
  endfunction

  a_r1_sum_value: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sum_q == $past(ref_add(opa, opb, cin)) % (1 << N));

  a_r2_carry_out: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cout_q == $past(ref_add(opa, opb, cin)) >> N);

  a_r3_reset_clears: assert property (@(posedge clk)
    rst |=> (sum_q == '0) && !cout_q);

  a_r4_skip_low_group: assert property (@(posedge clk) disable iff (rst)
    (&(opa[BW-1:0] ^ opb[BW-1:0])) |=> sum_q[BW-1:0] == {BW{~$past(cin)}});

  a_r5_bypass_matches_ripple: assert property (@(posedge clk) disable iff (rst)
    rip_co == skp_co);
endmodule

bind csk_adder_top csk_adder_chk #(.N(N), .BW(BW), .NG(NG)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .opa   (opa),
  .opb   (opb),
  .cin   (cin),
  .sum_q (sum_q),
  .cout_q(cout_q),
  .rip_co(rip_co),
  .skp_co(skp_co)
);

// File: tb/sim_csk_adder_top.sv
`timescale 1ns/1ps
module sim_csk_adder_top;
  localparam int unsigned N  = 20;
  localparam int unsigned BW = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] opa = '0;
  logic [N-1:0] opb = '0;
  logic         cin = 1'b0;
  logic [N-1:0] sum_q;
  logic         cout_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  csk_adder_top #(.N(N), .BW(BW)) u0 (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .cin(cin),
    .sum_q(sum_q), .cout_q(cout_q)
  );

  function automatic logic [N:0] golden(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [N:0] got, input logic [N:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
    @(negedge clk);
    opa = x; opb = y; cin = c;
    @(posedge clk);
    #1;
    check(req, {cout_q, sum_q}, golden(x, y, c));
  endtask

  initial begin
    void'($urandom(32'h5EED_0C5A));
    opa = 20'hABCDE; opb = 20'h12345; cin = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset", {cout_q, sum_q}, '0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 first add", {cout_q, sum_q}, golden(20'hABCDE, 20'h12345, 1'b1));
    // R3: outputs hold between edges while inputs change
    @(negedge clk);
    opa = 20'h00001; opb = 20'h00001; cin = 1'b0;
    #1;
    check("R3 hold", {cout_q, sum_q}, golden(20'hABCDE, 20'h12345, 1'b1));
    @(posedge clk);
    #1;
    check("R1 after hold", {cout_q, sum_q}, 21'h2);

    apply("R4 all propagate cin0", 20'hAAAAA, 20'h55555, 1'b0);
    check("R4 sum ones cout0", {cout_q, sum_q}, {1'b0, {N{1'b1}}});
    apply("R4 all propagate cin1", 20'hAAAAA, 20'h55555, 1'b1);
    check("R4 sum zero cout1", {cout_q, sum_q}, {1'b1, {N{1'b0}}});
    apply("R4 mixed pattern", 20'hF0F0F, 20'h0F0F0, 1'b1);

    apply("R5 generate in group0", 20'h00010, 20'h00010, 1'b0);
    check("R5 generate value", {cout_q, sum_q}, 21'h00020);
    apply("R5 kill stops carry", 20'hFFFFE, 20'h00000, 1'b1);
    check("R5 kill value", {cout_q, sum_q}, {1'b0, 20'hFFFFF});
    apply("R5 kill mid group", 20'h0001F, 20'h00000, 1'b1);
    check("R5 kill mid value", {cout_q, sum_q}, 21'h00020);

    // R6: group0 bit4 generates, groups 1..3 all propagate
    apply("R6 ripple through skips", 20'hAAAB0, 20'h55550, 1'b0);
    check("R6 carry reaches cout", {cout_q, sum_q}, {1'b1, 20'h00000});
    apply("R6 top bit generate", 20'h80000, 20'h80000, 1'b0);
    check("R6 top value", {cout_q, sum_q}, {1'b1, 20'h00000});

    apply("R7 zero plus cin", 20'h00000, 20'h00000, 1'b1);
    check("R7 zero value", {cout_q, sum_q}, 21'h1);
    apply("R7 max plus cin", 20'hFFFFF, 20'hFFFFF, 1'b1);
    check("R7 max value", {cout_q, sum_q}, {1'b1, 20'hFFFFF});

    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] x;
      logic [N-1:0] y;
      x = N'($urandom());
      y = N'($urandom());
      if (i % 4 == 1) y = ~x;
      if (i % 4 == 2) y = x ^ 20'h003E0;
      apply("R1 R2 random", x, y, 1'($urandom()));
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R3 reset again", {cout_q, sum_q}, '0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule